// File: doc/BRIEF.md
# Two-Class Prioritised Interrupt Controller

This block collects thirteen interrupt sources and turns them into two request lines toward a processor: a fast class and a normal class. Software steers every source into one of the two classes with a per-source class bit, gates it with a per-source enable bit, and acknowledges events through a sticky pending flag. The flag is set by the source and cleared by writing a one to its bit. Within a class the source with the lowest index wins. The controller drives that index to the processor next to the class request line.

The controller records, per class, whether a handler is currently running. The processor marks a handler as running with an acknowledge strobe and marks it as finished with a return strobe. Nesting is asymmetric. A running normal handler may be interrupted by a fast request but not by another normal one. While a fast handler runs, both request lines stay low. Two of the sources come from external pins and trigger on a falling edge. All other sources are one-cycle high pulses.

Top module: `fiq_irq_ctrl`

## Requirements
- R1: After reset the enable, class and pending registers read zero, no handler is marked as running, and both request lines are low.
- R2: A source event sets the source's pending flag, and the flag stays set until a register write at address 2 carries a one in that bit. If an event and a clear reach the same bit in the same cycle, the flag stays set.
- R3: Sources 5 and 6 are external pins. Their pending flag is set only when the pin is sampled high and then low on the next cycle. A rising edge or a steady level sets nothing. All other sources set their flag on any cycle where their input is high.
- R4: A source whose enable bit (address 0) is zero never causes a request, but its pending flag is still set.
- R5: Within a class, the request index is the lowest-numbered source that is pending and enabled. The order from index 0 to 12 is timer A, timer B, timer C, serial port, key change, external 1, external 2, 4096 Hz, 2048 Hz, 512 Hz, 64 Hz, 16 Hz, 2 Hz.
- R6: Class bit 1 (address 1) places a source in the fast class, driving fiq_req/fiq_src. Class bit 0 places it in the normal class, driving irq_req/irq_src. A source only ever competes within its own class.
- R7: While a normal handler is running, irq_req stays low, but fiq_req still follows the pending fast-class sources.
- R8: While a fast handler is running, both fiq_req and irq_req stay low.
- R9: An acknowledge marks its class as running on the next cycle, but only if that class's request line is high in the acknowledge cycle. Otherwise the acknowledge is ignored. A return strobe clears the running mark of its class on the next cycle.
- R10: Register reads are combinational: address 0 gives the enables, 1 the class bits, 2 the pending flags, and 3 reads zero. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| src_in | input | 13 | Source inputs; bits 5 and 6 are falling-edge pins, the rest high pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 13 | Register write data |
| reg_rdata | output | 13 | Register read data for reg_addr |
| fast_ack | input | 1 | Processor accepts the fast request |
| fast_ret | input | 1 | Processor leaves the fast handler |
| norm_ack | input | 1 | Processor accepts the normal request |
| norm_ret | input | 1 | Processor leaves the normal handler |
| fiq_req | output | 1 | Fast-class request |
| irq_req | output | 1 | Normal-class request |
| fiq_src | output | 4 | Winning fast-class source index |
| irq_src | output | 4 | Winning normal-class source index |

## Verification
A pulse source, a register write or a return strobe changes the outputs one clock edge later. The request lines and indices are combinational from the pending, enable, class and running registers. A falling-edge pin is seen one edge after the pin goes low, because the previous pin level sits in a register. Read data follows the address in the same cycle. The bench drives every stimulus at a falling clock edge and compares against its own model at the next falling edge, after exactly one rising edge. A near-exhaustive sweep covers every pair of sources and many pseudo-random enable, class and pending patterns, with and without handlers running.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned SRC_COUNT = 13;
  localparam int unsigned ADDR_W    = 2;

  // Source numbering; a lower index has a higher priority
  localparam int unsigned SRC_TMR_A  = 0;
  localparam int unsigned SRC_TMR_B  = 1;
  localparam int unsigned SRC_TMR_C  = 2;
  localparam int unsigned SRC_SERIAL = 3;
  localparam int unsigned SRC_KEY    = 4;
  localparam int unsigned SRC_PIN_1  = 5;
  localparam int unsigned SRC_PIN_2  = 6;
  localparam int unsigned SRC_TB_4K  = 7;
  localparam int unsigned SRC_TB_2K  = 8;
  localparam int unsigned SRC_TB_512 = 9;
  localparam int unsigned SRC_TB_64  = 10;
  localparam int unsigned SRC_TB_16  = 11;
  localparam int unsigned SRC_TB_2   = 12;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE = 2'd0,
    REG_CLASS  = 2'd1,
    REG_PEND   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intc_src_capture.sv
module intc_src_capture #(
  parameter int unsigned N = 13,
  parameter logic [N-1:0] EDGE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] ev;
  logic [N-1:0] pend_d;

  for (genvar i = 0; i < N; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_in[i];
      end
      assign ev[i] = prev_q & ~src_in[i];
    end else begin : g_pulse
      assign ev[i] = src_in[i];
    end
  end

  // event beats a simultaneous clear
  always_comb begin
    pend_d = (pend_q & ~clr_vec) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/intc_reg_bank.sv
module intc_reg_bank
  import intc_pkg::*;
#(
  parameter int unsigned N = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N-1:0]      reg_wdata,
  input  logic [N-1:0]      pend_q,
  output logic [N-1:0]      reg_rdata,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      sel_q,
  output logic [N-1:0]      clr_vec
);
  logic          en_ce, sel_ce;
  logic [N-1:0]  en_d, sel_d;
  reg_sel_e      addr_e;

  always_comb begin
    addr_e  = reg_sel_e'(reg_addr);
    en_ce   = reg_we && (addr_e == REG_ENABLE);
    sel_ce  = reg_we && (addr_e == REG_CLASS);
    clr_vec = (reg_we && (addr_e == REG_PEND)) ? reg_wdata : '0;
    en_d    = en_ce  ? reg_wdata : en_q;
    sel_d   = sel_ce ? reg_wdata : sel_q;
    unique case (addr_e)
      REG_ENABLE: reg_rdata = en_q;
      REG_CLASS:  reg_rdata = sel_q;
      REG_PEND:   reg_rdata = pend_q;
      default:    reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int unsigned N  = 13,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx
);
  // scan downward so the lowest set index is assigned last
  always_comb begin
    any = |cand;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/intc_svc_track.sv
module intc_svc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_ack,
  input  logic fast_ret,
  input  logic norm_ack,
  input  logic norm_ret,
  input  logic fiq_req,
  input  logic irq_req,
  output logic fiq_isr,
  output logic irq_isr
);
  logic fiq_isr_d, irq_isr_d;

  always_comb begin
    fiq_isr_d = fiq_isr;
    if (fast_ack && fiq_req) fiq_isr_d = 1'b1;
    else if (fast_ret)       fiq_isr_d = 1'b0;
    irq_isr_d = irq_isr;
    if (norm_ack && irq_req) irq_isr_d = 1'b1;
    else if (norm_ret)       irq_isr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_isr <= 1'b0;
      irq_isr <= 1'b0;
    end else begin
      fiq_isr <= fiq_isr_d;
      irq_isr <= irq_isr_d;
    end
  end
endmodule

// File: rtl/fiq_irq_ctrl.sv
module fiq_irq_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned N = SRC_COUNT,
  parameter logic [N-1:0] EDGE_MASK = N'((1 << SRC_PIN_1) | (1 << SRC_PIN_2)),
  localparam int unsigned IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N-1:0]      reg_wdata,
  output logic [N-1:0]      reg_rdata,
  input  logic              fast_ack,
  input  logic              fast_ret,
  input  logic              norm_ack,
  input  logic              norm_ret,
  output logic              fiq_req,
  output logic              irq_req,
  output logic [IW-1:0]     fiq_src,
  output logic [IW-1:0]     irq_src
);
  logic [N-1:0] pend, en, sel, clr_vec;
  logic [N-1:0] fiq_cand, irq_cand;
  logic         fiq_any, irq_any;
  logic         fiq_isr, irq_isr;

  intc_src_capture #(.N(N), .EDGE_MASK(EDGE_MASK)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .clr_vec(clr_vec), .pend_q(pend)
  );

  intc_reg_bank #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pend_q(pend), .reg_rdata(reg_rdata),
    .en_q(en), .sel_q(sel), .clr_vec(clr_vec)
  );

  always_comb begin
    fiq_cand = pend & en & sel;
    irq_cand = pend & en & ~sel;
  end

  intc_prio_pick #(.N(N), .IW(IW)) u_pick_fast (
    .cand(fiq_cand), .any(fiq_any), .idx(fiq_src)
  );

  intc_prio_pick #(.N(N), .IW(IW)) u_pick_norm (
    .cand(irq_cand), .any(irq_any), .idx(irq_src)
  );

  // fast handler blocks everything; normal handler blocks only normal
  always_comb begin
    fiq_req = fiq_any & ~fiq_isr;
    irq_req = irq_any & ~fiq_isr & ~irq_isr;
  end

  intc_svc_track u_svc (
    .clk(clk), .rst_n(rst_n), .fast_ack(fast_ack), .fast_ret(fast_ret),
    .norm_ack(norm_ack), .norm_ret(norm_ret), .fiq_req(fiq_req),
    .irq_req(irq_req), .fiq_isr(fiq_isr), .irq_isr(irq_isr)
  );
endmodule

// File: rtl/fiq_irq_ctrl_chk.sv
module fiq_irq_ctrl_chk #(
  parameter int unsigned N  = 13,
  parameter int unsigned IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  en,
  input logic [N-1:0]  sel,
  input logic [N-1:0]  clr_vec,
  input logic          fiq_isr,
  input logic          irq_isr,
  input logic          fast_ack,
  input logic          fast_ret,
  input logic          fiq_req,
  input logic          irq_req,
  input logic [IW-1:0] fiq_src,
  input logic [IW-1:0] irq_src
);
  p_fast_blocks_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_isr |-> (!fiq_req && !irq_req));

  p_norm_blocks_norm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_isr |-> !irq_req);

  p_pend_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend) & ~$past(clr_vec)) & ~pend) == '0));

  p_fast_src_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req |-> (pend[fiq_src] && en[fiq_src] && sel[fiq_src]));

  p_norm_src_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend[irq_src] && en[irq_src] && !sel[irq_src]));

  p_fast_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req |-> ((pend & en & sel & ((N'(1) << fiq_src) - N'(1))) == '0));

  p_disabled_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (!fiq_req && !irq_req));

  p_ack_enters_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_ack && fiq_req) |=> fiq_isr);

  p_ret_leaves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_ret && !(fast_ack && fiq_req)) |=> !fiq_isr);
endmodule

bind fiq_irq_ctrl fiq_irq_ctrl_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .en(en), .sel(sel),
  .clr_vec(clr_vec), .fiq_isr(fiq_isr), .irq_isr(irq_isr),
  .fast_ack(fast_ack), .fast_ret(fast_ret), .fiq_req(fiq_req),
  .irq_req(irq_req), .fiq_src(fiq_src), .irq_src(irq_src)
);

// File: tb/test_fiq_irq_ctrl.sv
`timescale 1ns/1ps
module test_fiq_irq_ctrl;
  localparam int N = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_in = '0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic          fast_ack = 1'b0, fast_ret = 1'b0, norm_ack = 1'b0, norm_ret = 1'b0;
  logic          fiq_req, irq_req;
  logic [3:0]    fiq_src, irq_src;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model
  logic [N-1:0] m_en = '0, m_sel = '0, m_pend = '0;
  bit m_fisr = 0, m_iisr = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  fiq_irq_ctrl i_fiq_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fast_ack(fast_ack), .fast_ret(fast_ret), .norm_ack(norm_ack),
    .norm_ret(norm_ret), .fiq_req(fiq_req), .irq_req(irq_req),
    .fiq_src(fiq_src), .irq_src(irq_src)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lowest(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic bit exp_f();
    return ((m_pend & m_en & m_sel) != '0) && !m_fisr;
  endfunction

  function automatic bit exp_i();
    return ((m_pend & m_en & ~m_sel) != '0) && !m_fisr && !m_iisr;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_outs(string tag);
    chk({tag, " fiq_req"}, int'(fiq_req), int'(exp_f()));
    chk({tag, " irq_req"}, int'(irq_req), int'(exp_i()));
    if (exp_f()) chk({tag, " fiq_src"}, int'(fiq_src), lowest(m_pend & m_en & m_sel));
    if (exp_i()) chk({tag, " irq_src"}, int'(irq_src), lowest(m_pend & m_en & ~m_sel));
  endtask

  task automatic reg_write(logic [1:0] a, logic [N-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
    case (a)
      2'd0: m_en = d;
      2'd1: m_sel = d;
      2'd2: m_pend = m_pend & ~d;
      default: ;
    endcase
  endtask

  task automatic reg_read(logic [1:0] a, output logic [N-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // internal bits pulse high for one cycle; pin bits go high then low
  task automatic fire(logic [N-1:0] mask);
    src_in = mask;
    step();
    src_in = '0;
    step();
    m_pend = m_pend | mask;
  endtask

  task automatic do_ack(bit fast);
    if (fast) begin
      fast_ack = 1'b1; if (exp_f()) m_fisr = 1;
    end else begin
      norm_ack = 1'b1; if (exp_i()) m_iisr = 1;
    end
    step();
    fast_ack = 1'b0; norm_ack = 1'b0;
  endtask

  task automatic do_ret(bit fast);
    if (fast) begin fast_ret = 1'b1; m_fisr = 0; end
    else      begin norm_ret = 1'b1; m_iisr = 0; end
    step();
    fast_ret = 1'b0; norm_ret = 1'b0;
  endtask

  function automatic logic [15:0] nxt(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [N-1:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), rd);
      chk("R1 reset register", int'(rd), 0);
    end
    chk("R1 reset fiq_req", int'(fiq_req), 0);
    chk("R1 reset irq_req", int'(irq_req), 0);

    // R10 spare address write ignored, enable/class unchanged
    reg_write(2'd0, 13'h0A5A);
    reg_write(2'd1, 13'h1234);
    reg_write(2'd3, 13'h1FFF);
    reg_read(2'd3, rd); chk("R10 spare reads zero", int'(rd), 0);
    reg_read(2'd0, rd); chk("R10 enable readback", int'(rd), int'(m_en));
    reg_read(2'd1, rd); chk("R10 class readback", int'(rd), int'(m_sel));

    // R4 disabled sources set pending but do not request
    reg_write(2'd0, '0);
    fire(13'h1FFF);
    reg_read(2'd2, rd); chk("R4 pending while disabled", int'(rd), 13'h1FFF);
    check_outs("R4 disabled");
    reg_write(2'd2, 13'h1FFF);
    reg_read(2'd2, rd); chk("R2 write-one clears", int'(rd), 0);

    // R3 pin sources: rising edge and held level set nothing
    reg_write(2'd0, 13'h1FFF);
    reg_write(2'd1, '0);
    src_in[5] = 1'b1; src_in[6] = 1'b1;
    step();
    reg_read(2'd2, rd); chk("R3 rising edge ignored", int'(rd), 0);
    repeat (3) step();
    reg_read(2'd2, rd); chk("R3 high level ignored", int'(rd), 0);
    check_outs("R3 no request");
    src_in[5] = 1'b0;
    step();
    reg_read(2'd2, rd); chk("R3 falling edge pin 5", int'(rd), 13'h0020);
    src_in[6] = 1'b0;
    step();
    m_pend = 13'h0060;
    reg_read(2'd2, rd); chk("R3 falling edge pin 6", int'(rd), 13'h0060);
    check_outs("R3 request after edge");
    reg_write(2'd2, 13'h0060);
    repeat (3) step();
    reg_read(2'd2, rd); chk("R3 low level ignored", int'(rd), 0);

    // R2 set and clear in the same cycle: set wins
    src_in[0] = 1'b1;
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 13'h0001;
    step();
    src_in = '0; reg_we = 1'b0; reg_wdata = '0;
    m_pend = 13'h0001;
    reg_read(2'd2, rd); chk("R2 set beats clear", int'(rd), 1);
    step();
    reg_read(2'd2, rd); chk("R2 sticky", int'(rd), 1);
    reg_write(2'd2, 13'h0001);

    // R9 acknowledge without request is ignored
    reg_write(2'd1, 13'h1FFF);
    do_ack(1'b1);
    do_ack(1'b0);
    fire(13'h0004);
    check_outs("R9 ack ignored without request");
    reg_write(2'd2, 13'h1FFF);

    // R5/R6 every source pair, class alternating by pair
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        reg_write(2'd1, ((i + j) % 2 == 0) ? 13'h1FFF : 13'h0000);
        fire(N'(1 << i) | N'(1 << j));
        check_outs("R5 pair priority");
        reg_write(2'd2, 13'h1FFF);
      end
    end

    // R4-R9 pseudo-random patterns with nesting
    for (int k = 0; k < 150; k++) begin
      lfsr = nxt(lfsr); reg_write(2'd0, lfsr[12:0] | 13'h0101);
      lfsr = nxt(lfsr); reg_write(2'd1, lfsr[12:0]);
      lfsr = nxt(lfsr); fire(lfsr[12:0]);
      check_outs("R6 class split");
      do_ack(1'b0);
      check_outs("R7 normal running");
      lfsr = nxt(lfsr); fire(lfsr[12:0]);
      check_outs("R7 fast may preempt");
      do_ack(1'b1);
      check_outs("R8 fast running");
      do_ack(1'b0);
      check_outs("R8 ack blocked");
      do_ret(1'b1);
      check_outs("R9 fast return");
      do_ret(1'b0);
      check_outs("R9 normal return");
      reg_write(2'd2, 13'h1FFF);
      reg_read(2'd2, rd); chk("R2 clear all", int'(rd), 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule